// File: doc/BRIEF.md
# Disk Transfer Termination and Result Sequencer

This block closes the data phase of a floppy-style disk controller and runs its result phase. A host moves sector bytes through a small FIFO. A media-side byte slot strobe (`media_tick`) drains the FIFO toward the media (write direction) or fills it from the media (read direction), one byte per strobe and one sector at a time. The block decides when a multi-sector transfer stops. The transfer can stop on the external terminal-count pin, on reaching the end-of-track sector, or on a FIFO underrun or overrun. A sector that is cut short is always carried to its full length inside the block.

When the transfer stops, the block raises an interrupt and presents seven result bytes through a byte-wide register read port. The main status register gates that port. While a result byte is not readable, a read returns the status register itself and leaves the sequence where it is. After the seventh byte has been read, the block is idle and accepts a new start strobe.

Top module: `dskx_term_seq`

## Requirements
- R1: After reset `msr` is 0x80 (bit 7 request-for-master, bit 6 direction-to-host, bit 5 executing, bit 4 busy; all other bits 0), `irq` and `drq` are 0. While idle, `tc_in` and `res_rd` leave `msr` at 0x80, and `reg_rdata` returns 0x80.
- R2: A `tc_in` pulse during the data phase ends the transfer after the current sector has been completed to SECT_LEN media byte slots. This is reported as normal termination: ST0 bits 7:6 = 00 and ST1 = 0x00.
- R3: With no terminal count and no FIFO fault, the transfer ends after the full sector whose number equals `cmd_eot`. This is reported as abnormal: ST0 bits 7:6 = 01 and ST1 bit 7 = 1.
- R4: In the write direction, a media slot that finds the FIFO empty is an underrun. In the read direction, a media slot that finds the FIFO full is an overrun. Either one ends the transfer once the current sector has been completed to SECT_LEN slots. It is reported as abnormal: ST0 bits 7:6 = 01 and ST1 bit 4 = 1.
- R5: Bytes cross the FIFO in arrival order in both directions. In the write direction, every media slot after the host's data has run out carries 0x00.
- R6: `drq` is 1 in the data phase while the host can move a byte (write: FIFO not full; read: FIFO not empty), and 0 from the cycle after any termination source.
- R7: `irq` rises together with the start of the result phase (`msr` = 0xD0) and falls after the first result byte read.
- R8: Result bytes come out in this order: ST0, ST1, ST2 (0x00), cylinder, head (0 or 1), last sector processed, size code. ST0 bit 2 carries the head. A `res_rd` while `msr` bit 7 is 0 returns `msr` on `reg_rdata` and does not advance the sequence.
- R9: After the seventh result read, `msr` is 0x80. A `cmd_start` during the result phase is ignored: `msr` stays 0xD0 and the result bytes are unchanged.
- R10: When terminal count and an end-of-track match end the same sector, terminal count wins and the transfer is reported as normal.
- R11: In a multi-sector transfer the sector number rises by one per completed sector, starting at `cmd_sector`. The result reports the last sector processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start strobe; accepted only while idle |
| cmd_dir_wr | input | 1 | 1 = host writes toward media, 0 = media to host |
| cmd_sector | input | 8 | First sector number |
| cmd_eot | input | 8 | End-of-track sector number |
| cmd_cyl | input | 8 | Cylinder reported in the result |
| cmd_head | input | 1 | Head reported in the result |
| cmd_size | input | 8 | Size code reported in the result |
| tc_in | input | 1 | External terminal count |
| host_we | input | 1 | Host data write into FIFO |
| host_wdata | input | 8 | Host write byte |
| host_re | input | 1 | Host data read from FIFO |
| host_rdata | output | 8 | FIFO head byte for host reads |
| drq | output | 1 | Data transfer request |
| media_tick | input | 1 | One media byte slot |
| media_rdata | input | 8 | Byte from media (read direction) |
| media_wstrobe | output | 1 | Media write slot this cycle |
| media_wdata | output | 8 | Byte to media; 0x00 when FIFO empty |
| res_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Result byte when readable, else `msr` |
| msr | output | 8 | Main status register |
| irq | output | 1 | Result-phase interrupt |

## Verification
The assertions assume that `res_rd` is a level sampled once per clock, with each cycle it is high counted as one read. They also assume that `cmd_start` arrives as a pulse and never as a held level. The bench drives every input at the falling edge. It pulses `cmd_start` for one cycle and `tc_in` for one cycle, and it raises `host_we` or `host_re` only when `drq` was seen high at that same falling edge. In the write direction, media slots start only after the FIFO has been prefilled, so an underrun arises only where a scenario means to cause one.

// File: rtl/dskx_pkg.sv
// Shared constants and types for the transfer termination / result sequencer.
// Assumes byte-wide result registers and a fixed seven-byte result set.
package dskx_pkg;
    localparam int MSR_RQM  = 7;
    localparam int MSR_DIO  = 6;
    localparam int MSR_EXEC = 5;
    localparam int MSR_BUSY = 4;

    localparam int RES_COUNT = 7;
    localparam int RES_IW    = $clog2(RES_COUNT);

    localparam logic [1:0] END_NORMAL   = 2'b00;
    localparam logic [1:0] END_ABNORMAL = 2'b01;

    localparam int ST1_EOT_BIT  = 7;
    localparam int ST1_FIFO_BIT = 4;
    localparam int ST0_HEAD_BIT = 2;

    // Why the last sector closed the transfer (end-of-track when neither set)
    typedef struct packed {
        logic by_tc;
        logic by_fifo;
    } end_cause_t;
endpackage

// File: rtl/dskx_fifo.sv
// Byte FIFO between host and media sides.
// Assumes DEPTH is a power of two; push when full and pop when empty are dropped.
// rdata shows the head entry combinationally.
module dskx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign rdata   = mem[rptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dskx_media_ctl.sv
// Media-side byte engine: counts byte slots within a sector and steps sectors.
// It latches the termination sources (terminal count, FIFO fault) and fires a
// one-cycle done strobe on the last slot of the closing sector.
// Assumes start arrives only while the whole block is idle and SECT_LEN >= 2.
module dskx_media_ctl
    import dskx_pkg::*;
#(
    parameter int SECT_LEN = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_dir_wr,
    input  logic [7:0] start_sec,
    input  logic [7:0] start_eot,
    input  logic       tc_in,
    input  logic       media_tick,
    input  logic       fifo_empty,
    input  logic       fifo_full,
    output logic       active,
    output logic       dir_wr,
    output logic       stopping,
    output logic       media_push,
    output logic       media_pop,
    output logic       wstrobe,
    output logic       done,
    output end_cause_t cause,
    output logic [7:0] sector
);
    localparam int BW = $clog2(SECT_LEN);
    localparam logic [BW-1:0] LAST = BW'(SECT_LEN - 1);

    logic [BW-1:0] cnt;
    logic [7:0]    eot;
    logic          tc_seen, err_seen;
    logic          tick, err_now, term_any, last_slot;

    // Slot qualification and termination decode
    always_comb begin
        tick      = active && media_tick;
        err_now   = tick && !stopping && (dir_wr ? fifo_empty : fifo_full);
        term_any  = stopping || tc_in || err_now;
        last_slot = tick && (cnt == LAST);
        done      = last_slot && (term_any || sector == eot);
    end

    assign media_pop  = tick && dir_wr && !fifo_empty;
    assign media_push = tick && !dir_wr && !stopping && !tc_in && !fifo_full;
    assign wstrobe    = tick && dir_wr;
    assign cause      = '{by_tc: tc_seen || tc_in, by_fifo: err_seen || err_now};

    // Sector progress and termination flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            dir_wr   <= 1'b0;
            stopping <= 1'b0;
            tc_seen  <= 1'b0;
            err_seen <= 1'b0;
            cnt      <= '0;
            sector   <= '0;
            eot      <= '0;
        end else if (start) begin
            active   <= 1'b1;
            dir_wr   <= start_dir_wr;
            stopping <= 1'b0;
            tc_seen  <= 1'b0;
            err_seen <= 1'b0;
            cnt      <= '0;
            sector   <= start_sec;
            eot      <= start_eot;
        end else if (active) begin
            if (tc_in) begin
                tc_seen  <= 1'b1;
                stopping <= 1'b1;
            end
            if (err_now) begin
                err_seen <= 1'b1;
                stopping <= 1'b1;
            end
            if (tick) begin
                if (last_slot) begin
                    if (done) begin
                        active <= 1'b0;
                    end else begin
                        sector <= sector + 8'd1;
                        cnt    <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dskx_result_seq.sv
// Result-phase sequencer: on the done strobe it captures seven status bytes,
// raises the interrupt and steps through the bytes one per read.
// Assumes res_rd is presented only when the caller allows a result read.
module dskx_result_seq
    import dskx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  end_cause_t        cause,
    input  logic [7:0]        sector,
    input  logic [7:0]        cyl,
    input  logic              head,
    input  logic [7:0]        size,
    input  logic              res_rd,
    output logic              active,
    output logic              irq,
    output logic [RES_IW-1:0] idx,
    output logic [7:0]        byte_out
);
    localparam logic [RES_IW-1:0] LAST_IDX = RES_IW'(RES_COUNT - 1);

    logic [7:0] res_q [RES_COUNT];
    logic [1:0] code;
    logic [7:0] st0, st1;

    // Completion code and status byte build
    always_comb begin
        code = END_NORMAL;
        st1  = 8'h00;
        if (cause.by_fifo) begin
            code              = END_ABNORMAL;
            st1[ST1_FIFO_BIT] = 1'b1;
        end else if (!cause.by_tc) begin
            code             = END_ABNORMAL;
            st1[ST1_EOT_BIT] = 1'b1;
        end
        st0               = {code, 6'b000000};
        st0[ST0_HEAD_BIT] = head;
    end

    // Capture of the result set at termination
    always_ff @(posedge clk) begin
        if (done) begin
            res_q[0] <= st0;
            res_q[1] <= st1;
            res_q[2] <= 8'h00;
            res_q[3] <= cyl;
            res_q[4] <= {7'b0000000, head};
            res_q[5] <= sector;
            res_q[6] <= size;
        end
    end

    // Read sequencing and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            irq    <= 1'b0;
            idx    <= '0;
        end else if (done) begin
            active <= 1'b1;
            irq    <= 1'b1;
            idx    <= '0;
        end else if (active && res_rd) begin
            irq <= 1'b0;
            if (idx == LAST_IDX) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
        end
    end

    assign byte_out = res_q[idx];
endmodule

// File: rtl/dskx_term_seq.sv
// Top: transfer termination and result handshake of a disk controller.
// Joins the FIFO, the media engine and the result sequencer, and builds the
// main status register and the register read port.
// Assumes cmd_start is a single-cycle pulse; it is dropped unless the block is idle.
module dskx_term_seq
    import dskx_pkg::*;
#(
    parameter int SECT_LEN   = 128,
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_dir_wr,
    input  logic [7:0] cmd_sector,
    input  logic [7:0] cmd_eot,
    input  logic [7:0] cmd_cyl,
    input  logic       cmd_head,
    input  logic [7:0] cmd_size,
    input  logic       tc_in,
    input  logic       host_we,
    input  logic [7:0] host_wdata,
    input  logic       host_re,
    output logic [7:0] host_rdata,
    output logic       drq,
    input  logic       media_tick,
    input  logic [7:0] media_rdata,
    output logic       media_wstrobe,
    output logic [7:0] media_wdata,
    input  logic       res_rd,
    output logic [7:0] reg_rdata,
    output logic [7:0] msr,
    output logic       irq
);
    logic              xfer_active, dir_wr, stopping, done;
    logic              media_push, media_pop;
    logic              res_active, accept;
    logic              fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic              host_push, host_pop;
    logic [7:0]        fifo_rdata, fifo_wdata, sector, res_byte;
    logic [7:0]        cyl_q, size_q;
    logic              head_q;
    logic [RES_IW-1:0] res_idx;
    end_cause_t        cause;

    assign accept = cmd_start && !xfer_active && !res_active;

    // Command fields reported in the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q  <= '0;
            head_q <= 1'b0;
            size_q <= '0;
        end else if (accept) begin
            cyl_q  <= cmd_cyl;
            head_q <= cmd_head;
            size_q <= cmd_size;
        end
    end

    // Host-side FIFO access and FIFO port steering
    always_comb begin
        host_push  = host_we && xfer_active && dir_wr && !stopping && !fifo_full;
        host_pop   = host_re && xfer_active && !dir_wr && !fifo_empty;
        fifo_push  = host_push || media_push;
        fifo_pop   = host_pop || media_pop;
        fifo_wdata = dir_wr ? host_wdata : media_rdata;
    end

    dskx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    dskx_media_ctl #(.SECT_LEN(SECT_LEN)) u_media (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .start_dir_wr (cmd_dir_wr),
        .start_sec    (cmd_sector),
        .start_eot    (cmd_eot),
        .tc_in        (tc_in),
        .media_tick   (media_tick),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .active       (xfer_active),
        .dir_wr       (dir_wr),
        .stopping     (stopping),
        .media_push   (media_push),
        .media_pop    (media_pop),
        .wstrobe      (media_wstrobe),
        .done         (done),
        .cause        (cause),
        .sector       (sector)
    );

    dskx_result_seq u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .cause    (cause),
        .sector   (sector),
        .cyl      (cyl_q),
        .head     (head_q),
        .size     (size_q),
        .res_rd   (res_rd && msr[MSR_RQM] && msr[MSR_DIO]),
        .active   (res_active),
        .irq      (irq),
        .idx      (res_idx),
        .byte_out (res_byte)
    );

    // Status register and read-port selection
    always_comb begin
        msr            = 8'h00;
        msr[MSR_RQM]   = !xfer_active;
        msr[MSR_DIO]   = res_active || (xfer_active && !dir_wr);
        msr[MSR_EXEC]  = xfer_active;
        msr[MSR_BUSY]  = xfer_active || res_active;
        reg_rdata      = (msr[MSR_RQM] && msr[MSR_DIO]) ? res_byte : msr;
        drq            = xfer_active && !stopping && (dir_wr ? !fifo_full : !fifo_empty);
        host_rdata     = fifo_rdata;
        media_wdata    = fifo_empty ? 8'h00 : fifo_rdata;
    end
endmodule

// File: rtl/dskx_term_seq_chk.sv
// Property checker for dskx_term_seq, bound onto every instance of the top.
// Assumes res_rd is sampled as one read per high cycle.
module dskx_term_seq_chk
    import dskx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        msr,
    input logic              irq,
    input logic              drq,
    input logic              res_rd,
    input logic              cmd_start,
    input logic              media_wstrobe,
    input logic [RES_IW-1:0] res_idx
);
    // Interrupt only while result bytes are readable
    assert_irq_in_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msr[MSR_RQM] && msr[MSR_DIO] && msr[MSR_BUSY]));

    // First read drops the interrupt
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && res_rd) |=> !irq);

    // Transfer request only in the data phase
    assert_drq_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> msr[MSR_EXEC]);

    // Media writes only in the data phase
    assert_wstrobe_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        media_wstrobe |-> msr[MSR_EXEC]);

    // Read with request-for-master low does not move the sequence
    assert_rd_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr[MSR_RQM] && res_rd) |=> $stable(res_idx));

    // Readable result read advances by one
    assert_rd_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[MSR_RQM] && msr[MSR_DIO] && res_rd && res_idx != RES_IW'(RES_COUNT - 1))
        |=> (res_idx == $past(res_idx) + 1'b1));

    // Start strobe during result phase keeps the block busy
    assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[MSR_RQM] && msr[MSR_DIO] && cmd_start) |=> msr[MSR_BUSY]);

    // Leaving busy lands in idle with only request-for-master set
    assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msr[MSR_BUSY]) |-> (msr == 8'h80));
endmodule

bind dskx_term_seq dskx_term_seq_chk u_chk (.*);

// File: tb/dskx_term_seq_test.sv
// Self-checking bench: a scenario table walked by one loop, then directed idle checks.
module dskx_term_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0, cmd_dir_wr = 1'b0, cmd_head = 1'b0;
    logic [7:0] cmd_sector = '0, cmd_eot = '0, cmd_cyl = '0, cmd_size = '0;
    logic       tc_in = 1'b0, host_we = 1'b0, host_re = 1'b0, media_tick = 1'b0, res_rd = 1'b0;
    logic [7:0] host_wdata = '0, media_rdata = '0;
    logic [7:0] host_rdata, media_wdata, reg_rdata, msr;
    logic       drq, media_wstrobe, irq;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dskx_term_seq uut (.*);

    typedef struct packed {
        logic        dir;
        logic [7:0]  sec;
        logic [7:0]  eot;
        logic [7:0]  cyl;
        logic        head;
        logic [7:0]  size;
        logic [15:0] host_n;
        logic        use_tc;
        logic [7:0]  st0;
        logic [7:0]  st1;
        logic [7:0]  rsec;
        logic [15:0] nbytes;
    } scn_t;

    // dir, sec, eot, cyl, head, size, host bytes, tc, ST0, ST1, sector, media slots
    localparam scn_t SCN [6] = '{
        '{1'b1, 8'd1, 8'd1,  8'd5, 1'b0, 8'd0, 16'd128, 1'b0, 8'h40, 8'h80, 8'd1, 16'd128},
        '{1'b1, 8'd1, 8'd5,  8'd9, 1'b1, 8'd1, 16'd200, 1'b1, 8'h04, 8'h00, 8'd2, 16'd256},
        '{1'b1, 8'd3, 8'd9,  8'd2, 1'b0, 8'd0, 16'd100, 1'b0, 8'h40, 8'h10, 8'd3, 16'd128},
        '{1'b0, 8'd2, 8'd3,  8'd7, 1'b1, 8'd0, 16'd999, 1'b0, 8'h44, 8'h80, 8'd3, 16'd256},
        '{1'b0, 8'd7, 8'd20, 8'd0, 1'b0, 8'd2, 16'd0,   1'b0, 8'h40, 8'h10, 8'd7, 16'd128},
        '{1'b0, 8'd4, 8'd4,  8'd3, 1'b1, 8'd0, 16'd50,  1'b1, 8'h04, 8'h00, 8'd4, 16'd128}
    };

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_scn(input scn_t s, input int n);
        int hw = 0, hr = 0, mc = 0, cyc = 0, tc_cyc = -10, bad = 0;
        logic tc_sent = 1'b0;
        logic [7:0] exp_res [7];
        exp_res = '{s.st0, s.st1, 8'h00, s.cyl, {7'b0, s.head}, s.rsec, s.size};
        @(negedge clk);
        cmd_dir_wr = s.dir; cmd_sector = s.sec; cmd_eot = s.eot;
        cmd_cyl = s.cyl; cmd_head = s.head; cmd_size = s.size; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!irq && cyc < 4000) begin
            if (tc_sent && cyc == tc_cyc + 1)
                check(drq == 1'b0, "R6 drq drop after tc", drq, 0);
            host_we    = s.dir && (hw < int'(s.host_n)) && drq;
            host_wdata = pat(hw);
            host_re    = !s.dir && (hr < int'(s.host_n)) && drq;
            tc_in      = 1'b0;
            if (s.use_tc && !tc_sent && (s.dir ? hw == int'(s.host_n) : hr == int'(s.host_n))) begin
                tc_in = 1'b1; tc_sent = 1'b1; tc_cyc = cyc;
            end
            media_tick  = (cyc >= 8) && cyc[0];
            media_rdata = 8'(mc);
            res_rd      = (cyc == 3);
            #1;
            if (cyc == 3)
                check(reg_rdata == (s.dir ? 8'h30 : 8'h70), "R8 blocked read gives msr",
                      reg_rdata, s.dir ? 8'h30 : 8'h70);
            if (cyc == 4 && s.dir)
                check(drq == 1'b1, "R6 drq in write data phase", drq, 1);
            if (host_re && host_rdata != 8'(hr)) bad++;
            if (media_wstrobe && media_wdata != ((mc < int'(s.host_n)) ? pat(mc) : 8'h00)) bad++;
            if (host_we) hw++;
            if (host_re) hr++;
            if (media_tick) mc++;
            @(negedge clk);
            cyc++;
        end
        host_we = 1'b0; host_re = 1'b0; tc_in = 1'b0; media_tick = 1'b0; res_rd = 1'b0;
        check(irq == 1'b1, $sformatf("R7 irq at result start scn%0d", n), irq, 1);
        check(bad == 0, $sformatf("R5 byte order / zero fill scn%0d", n), bad, 0);
        check(mc == int'(s.nbytes), $sformatf("R2 R4 R11 media slots scn%0d", n), mc, s.nbytes);
        check(msr == 8'hD0, "R7 msr in result phase", msr, 8'hD0);
        // start strobe during the result phase
        cmd_sector = 8'hEE; cmd_cyl = 8'hEE; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(msr == 8'hD0, "R9 start ignored in result phase", msr, 8'hD0);
        for (int k = 0; k < 7; k++) begin
            res_rd = 1'b1;
            #1;
            check(reg_rdata == exp_res[k],
                  $sformatf("R8 R3 R10 R11 result byte %0d scn%0d", k, n), reg_rdata, exp_res[k]);
            @(negedge clk);
            if (k == 0) check(irq == 1'b0, "R7 irq falls after first read", irq, 0);
        end
        res_rd = 1'b0;
        check(msr == 8'h80, "R9 idle after last read", msr, 8'h80);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(msr == 8'h80, "R1 reset msr", msr, 8'h80);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        check(drq == 1'b0, "R1 reset drq", drq, 0);
        for (int i = 0; i < 6; i++) run_scn(SCN[i], i);
        // directed: idle ignores terminal count and register reads
        tc_in = 1'b1; res_rd = 1'b1;
        #1;
        check(reg_rdata == 8'h80, "R1 idle read returns msr", reg_rdata, 8'h80);
        @(negedge clk);
        tc_in = 1'b0; res_rd = 1'b0;
        check(msr == 8'h80, "R1 idle tc ignored", msr, 8'h80);
        check(irq == 1'b0, "R1 idle no irq", irq, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule